// File: doc/BRIEF.md
# Prefetch Candidate Queue Manager

This block sits beside a cache and holds a bounded list of pending hardware prefetch requests, each an aligned block address with the time at which it becomes ready. The prefetch algorithm supplies candidate addresses, each with a delay. The cache control supplies demand-miss notifications. Before a candidate is stored, the block checks it against the cache contents, the outstanding-miss queue and its own entries. A miss to a queued block removes that entry. When squash mode is on, a miss also discards queued work from the tail that would become ready no earlier than the miss.

The memory side asks for work through an issue handshake and receives the oldest entry. When cache checks are deferred to issue time, entries already present in the cache are dropped there, one per cycle. A bus-request flag and its ready time tell the arbiter that prefetch work is waiting. Six event counters record what happened to candidates and entries.

Top module: `pf_cand_queue`

## Requirements
- R1: Every address the block compares or emits (lookup addresses, stored and issued addresses) is a block address: the low log2(BLK_BYTES) bits are zero.
- R2: A miss with `miss_uncached` set is accepted and then ignored. With DATA_ONLY set, a miss with `miss_ifetch` set is also ignored. An ignored miss changes no entry, no counter and no candidate time base.
- R3: A qualifying miss takes one cycle to delete the queued entry whose block equals the miss block, if there is one, and increments `cnt_missrm`.
- R4: With SERIAL_SQUASH set, the cycles after the match step drop the tail entry, one per cycle, for as long as the tail's ready time is greater than or equal to the miss time. Each drop increments `cnt_squash`.
- R5: A candidate's ready time is the time of the most recent qualifying miss (zero after reset) plus `cand_delay`, modulo 2^TW.
- R6: An accepted candidate is dropped if `mq_hit` is high or if its block is already queued. A queue hit increments `cnt_dupq`. `cl_hit` drops it only when CHECK_AT_INSERT is set.
- R7: A candidate stored while the queue holds DEPTH entries first discards the head entry and increments `cnt_evict`.
- R8: Each stored candidate sets `breq` and loads `breq_time` with its ready time. `breq` clears in the cycle after any removal leaves the queue empty.
- R9: An accepted issue request pops entries in arrival order. With CHECK_AT_INSERT clear, a popped entry whose block `cl_hit` reports present is dropped and the next one is tried in the following cycle. A response with `rsp_found` high carries the entry. When nothing is left, the response has `rsp_found` low.
- R10: Priority in the idle state is miss, then candidate, then issue. `miss_ready` is high only when idle. `cand_ready` additionally needs `miss_valid` low, and `iss_ready` needs both valids low. At most one candidate is taken per clock.
- R11: `cnt_ident` counts every accepted candidate, and `cnt_issued` counts every response with `rsp_found` high.
- R12: After reset, the queue is empty, `breq` and all counters are zero, and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Demand miss offered |
| miss_ready | output | 1 | Miss accepted this cycle |
| miss_addr | input | AW | Miss byte address |
| miss_time | input | TW | Time of the miss |
| miss_uncached | input | 1 | Miss is to uncacheable space |
| miss_ifetch | input | 1 | Miss is an instruction fetch |
| cand_valid | input | 1 | Candidate offered |
| cand_ready | output | 1 | Candidate accepted this cycle |
| cand_addr | input | AW | Candidate byte address |
| cand_delay | input | DLW | Candidate delay after the miss time |
| cl_addr | output | AW | Cache lookup block address |
| cl_hit | input | 1 | Block at `cl_addr` is in the cache (same cycle) |
| mq_addr | output | AW | Miss-queue lookup block address |
| mq_hit | input | 1 | Block at `mq_addr` is outstanding (same cycle) |
| iss_req | input | 1 | Memory side asks for a prefetch |
| iss_ready | output | 1 | Issue request accepted this cycle |
| rsp_valid | output | 1 | Issue response this cycle |
| rsp_found | output | 1 | Response carries an entry |
| rsp_addr | output | AW | Issued block address |
| rsp_time | output | TW | Issued ready time |
| breq | output | 1 | Bus request for prefetch work |
| breq_time | output | TW | Ready time of the latest stored entry |
| cnt_ident | output | CNT_W | Candidates accepted |
| cnt_dupq | output | CNT_W | Candidates already queued |
| cnt_evict | output | CNT_W | Heads discarded because the queue was full |
| cnt_missrm | output | CNT_W | Entries removed by a matching miss |
| cnt_issued | output | CNT_W | Entries issued |
| cnt_squash | output | CNT_W | Entries squashed from the tail |

## Verification
The checker checks on every cycle the relations that hold at the ports at any time. These are the handshake priority, the alignment of every emitted address, and that `breq` rises only after an accepted candidate. They also cover each counter step: it must follow the handshake or response that causes it, and squash counts occur only while candidates are stalled. Only the bench's reference queue can show which entry a miss deletes, how far a squash reaches into the tail, and which head is lost on overflow. The same holds for the order of issued entries, the skipping of cached entries at issue, and ready times built from the latest qualifying miss. The bench compares all outputs against that model on every clock. It uses fill-heavy, mixed and drain-heavy traffic.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_MATCH  = 2'd1,
      ST_SQUASH = 2'd2,
      ST_ISSUE  = 2'd3
   } pfq_state_e;

   typedef enum logic [2:0] {
      OP_NONE         = 3'd0,
      OP_APPEND       = 3'd1,
      OP_EVICT_APPEND = 3'd2,
      OP_DELETE       = 3'd3,
      OP_DROP_TAIL    = 3'd4
   } pfq_op_e;

   localparam int NSTAT        = 6;
   localparam int STAT_IDENT   = 0;
   localparam int STAT_DUPQ    = 1;
   localparam int STAT_EVICT   = 2;
   localparam int STAT_MISSRM  = 3;
   localparam int STAT_ISSUED  = 4;
   localparam int STAT_SQUASH  = 5;

endpackage

// File: rtl/pfq_match.sv
module pfq_match #(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic [AW-1:0]    tags [DEPTH],
   input  logic [DEPTH-1:0] live,
   input  logic [AW-1:0]    key,
   output logic             hit,
   output logic [IW-1:0]    hit_idx
);

   logic [DEPTH-1:0] eq;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign eq[g] = live[g] && (tags[g] == key);
   end

   assign hit = |eq;

   always_comb begin
      hit_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (eq[i]) hit_idx = IW'(i);
      end
   end

endmodule

// File: rtl/pfq_store.sv
module pfq_store
   import pfq_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   parameter int TW    = 16,
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  pfq_op_e       op,
   input  logic [IW-1:0] op_idx,
   input  logic [AW-1:0] wr_addr,
   input  logic [TW-1:0] wr_time,
   input  logic [AW-1:0] cmp_key,
   output logic [CW-1:0] count,
   output logic [AW-1:0] head_addr,
   output logic [TW-1:0] head_time,
   output logic [TW-1:0] tail_time,
   output logic          hit,
   output logic [IW-1:0] hit_idx
);

   logic [AW-1:0]    addr_q [DEPTH];
   logic [TW-1:0]    time_q [DEPTH];
   logic [DEPTH-1:0] live;
   logic [IW-1:0]    wr_idx;
   logic [IW-1:0]    tail_idx;

   assign wr_idx   = IW'(count);
   assign tail_idx = IW'(count - 1'b1);

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [AW-1:0] up_addr;
      logic [TW-1:0] up_time;

      if (g == DEPTH - 1) begin : g_last
         assign up_addr = wr_addr;
         assign up_time = wr_time;
      end else begin : g_mid
         assign up_addr = addr_q[g+1];
         assign up_time = time_q[g+1];
      end

      assign live[g] = CW'(g) < count;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_q[g] <= '0;
            time_q[g] <= '0;
         end else begin
            case (op)
               OP_APPEND: begin
                  if (wr_idx == IW'(g)) begin
                     addr_q[g] <= wr_addr;
                     time_q[g] <= wr_time;
                  end
               end
               OP_EVICT_APPEND: begin
                  addr_q[g] <= up_addr;
                  time_q[g] <= up_time;
               end
               OP_DELETE: begin
                  if ((IW'(g) >= op_idx) && (g < DEPTH - 1)) begin
                     addr_q[g] <= up_addr;
                     time_q[g] <= up_time;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else begin
         case (op)
            OP_APPEND:                count <= count + 1'b1;
            OP_DELETE, OP_DROP_TAIL:  count <= count - 1'b1;
            default: ;
         endcase
      end
   end

   assign head_addr = addr_q[0];
   assign head_time = time_q[0];
   assign tail_time = time_q[tail_idx];

   pfq_match #(
      .DEPTH (DEPTH),
      .AW    (AW)
   ) u_match (
      .tags    (addr_q),
      .live    (live),
      .key     (cmp_key),
      .hit     (hit),
      .hit_idx (hit_idx)
   );

endmodule

// File: rtl/pfq_stats.sv
module pfq_stats #(
   parameter int N     = 6,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     inc,
   output logic [CNT_W-1:0] cnt [N]
);

   for (genvar g = 0; g < N; g++) begin : g_cnt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt[g] <= '0;
         else if (inc[g]) cnt[g] <= cnt[g] + 1'b1;
      end
   end

endmodule

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
   import pfq_pkg::*;
#(
   parameter int DEPTH           = 8,
   parameter int AW              = 32,
   parameter int TW              = 16,
   parameter int DLW             = 8,
   parameter int OFF             = 6,
   parameter bit SERIAL_SQUASH   = 1'b1,
   parameter bit CHECK_AT_INSERT = 1'b0,
   parameter bit DATA_ONLY       = 1'b1,
   localparam int IW             = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW             = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             miss_valid,
   output logic             miss_ready,
   input  logic [AW-1:0]    miss_addr,
   input  logic [TW-1:0]    miss_time,
   input  logic             miss_uncached,
   input  logic             miss_ifetch,
   input  logic             cand_valid,
   output logic             cand_ready,
   input  logic [AW-1:0]    cand_addr,
   input  logic [DLW-1:0]   cand_delay,
   output logic [AW-1:0]    cl_addr,
   input  logic             cl_hit,
   output logic [AW-1:0]    mq_addr,
   input  logic             mq_hit,
   input  logic             iss_req,
   output logic             iss_ready,
   output logic             rsp_valid,
   output logic             rsp_found,
   output logic [AW-1:0]    rsp_addr,
   output logic [TW-1:0]    rsp_time,
   output logic             breq,
   output logic [TW-1:0]    breq_time,
   output pfq_op_e          op,
   output logic [IW-1:0]    op_idx,
   output logic [AW-1:0]    wr_addr,
   output logic [TW-1:0]    wr_time,
   output logic [AW-1:0]    cmp_key,
   input  logic [CW-1:0]    count,
   input  logic [AW-1:0]    head_addr,
   input  logic [TW-1:0]    head_time,
   input  logic [TW-1:0]    tail_time,
   input  logic             hit,
   input  logic [IW-1:0]    hit_idx,
   output logic [NSTAT-1:0] stat_inc
);

   localparam logic [AW-1:0] BLK_MASK = {AW{1'b1}} << OFF;

   pfq_state_e    st, st_n;
   logic [AW-1:0] mblk_q;
   logic [TW-1:0] mtime_q;
   logic [TW-1:0] ltime_q;
   logic [AW-1:0] miss_blk, cand_blk;
   logic [TW-1:0] cand_time;
   logic          idle, empty, full;
   logic          miss_take, miss_ok, cand_take, iss_take;
   logic          drop_at_insert, skip_at_issue;
   logic          inserting, removing;

   assign miss_blk  = miss_addr & BLK_MASK;
   assign cand_blk  = cand_addr & BLK_MASK;
   assign cand_time = ltime_q + TW'(cand_delay);
   assign idle      = (st == ST_IDLE);
   assign empty     = (count == '0);
   assign full      = (count == CW'(DEPTH));

   assign miss_ready = idle;
   assign cand_ready = idle && !miss_valid;
   assign iss_ready  = idle && !miss_valid && !cand_valid;

   assign miss_take = miss_valid && miss_ready;
   assign cand_take = cand_valid && cand_ready;
   assign iss_take  = iss_req && iss_ready;

   if (DATA_ONLY) begin : g_data_only
      assign miss_ok = !miss_uncached && !miss_ifetch;
   end else begin : g_all_misses
      assign miss_ok = !miss_uncached;
   end

   if (CHECK_AT_INSERT) begin : g_chk_insert
      assign drop_at_insert = cl_hit;
      assign skip_at_issue  = 1'b0;
   end else begin : g_chk_issue
      assign drop_at_insert = 1'b0;
      assign skip_at_issue  = cl_hit;
   end

   assign cmp_key   = (st == ST_MATCH) ? mblk_q : cand_blk;
   assign cl_addr   = (st == ST_ISSUE) ? head_addr : cand_blk;
   assign mq_addr   = cand_blk;
   assign wr_addr   = cand_blk;
   assign wr_time   = cand_time;
   assign rsp_addr  = head_addr;
   assign rsp_time  = head_time;

   always_comb begin
      st_n      = st;
      op        = OP_NONE;
      op_idx    = '0;
      stat_inc  = '0;
      rsp_valid = 1'b0;
      rsp_found = 1'b0;
      case (st)
         ST_IDLE: begin
            if (miss_take) begin
               if (miss_ok) st_n = ST_MATCH;
            end else if (cand_take) begin
               stat_inc[STAT_IDENT] = 1'b1;
               if (drop_at_insert || mq_hit) begin
                  op = OP_NONE;
               end else if (hit) begin
                  stat_inc[STAT_DUPQ] = 1'b1;
               end else if (full) begin
                  op = OP_EVICT_APPEND;
                  stat_inc[STAT_EVICT] = 1'b1;
               end else begin
                  op = OP_APPEND;
               end
            end else if (iss_take) begin
               st_n = ST_ISSUE;
            end
         end
         ST_MATCH: begin
            if (hit) begin
               op     = OP_DELETE;
               op_idx = hit_idx;
               stat_inc[STAT_MISSRM] = 1'b1;
            end
            st_n = SERIAL_SQUASH ? ST_SQUASH : ST_IDLE;
         end
         ST_SQUASH: begin
            if (!empty && (tail_time >= mtime_q)) begin
               op = OP_DROP_TAIL;
               stat_inc[STAT_SQUASH] = 1'b1;
            end else begin
               st_n = ST_IDLE;
            end
         end
         ST_ISSUE: begin
            if (empty) begin
               rsp_valid = 1'b1;
               st_n      = ST_IDLE;
            end else begin
               op = OP_DELETE;
               if (!skip_at_issue) begin
                  rsp_valid = 1'b1;
                  rsp_found = 1'b1;
                  stat_inc[STAT_ISSUED] = 1'b1;
                  st_n = ST_IDLE;
               end
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   assign inserting = (op == OP_APPEND) || (op == OP_EVICT_APPEND);
   assign removing  = (op == OP_DELETE) || (op == OP_DROP_TAIL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         mblk_q    <= '0;
         mtime_q   <= '0;
         ltime_q   <= '0;
         breq      <= 1'b0;
         breq_time <= '0;
      end else begin
         st <= st_n;
         if (miss_take && miss_ok) begin
            mblk_q  <= miss_blk;
            mtime_q <= miss_time;
            ltime_q <= miss_time;
         end
         if (inserting) begin
            breq      <= 1'b1;
            breq_time <= cand_time;
         end else if (removing && (count == CW'(1))) begin
            breq <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pf_cand_queue.sv
module pf_cand_queue
   import pfq_pkg::*;
#(
   parameter int DEPTH           = 8,
   parameter int AW              = 32,
   parameter int TW              = 16,
   parameter int DLW             = 8,
   parameter int BLK_BYTES       = 64,
   parameter int CNT_W           = 16,
   parameter bit SERIAL_SQUASH   = 1'b1,
   parameter bit CHECK_AT_INSERT = 1'b0,
   parameter bit DATA_ONLY       = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             miss_valid,
   output logic             miss_ready,
   input  logic [AW-1:0]    miss_addr,
   input  logic [TW-1:0]    miss_time,
   input  logic             miss_uncached,
   input  logic             miss_ifetch,
   input  logic             cand_valid,
   output logic             cand_ready,
   input  logic [AW-1:0]    cand_addr,
   input  logic [DLW-1:0]   cand_delay,
   output logic [AW-1:0]    cl_addr,
   input  logic             cl_hit,
   output logic [AW-1:0]    mq_addr,
   input  logic             mq_hit,
   input  logic             iss_req,
   output logic             iss_ready,
   output logic             rsp_valid,
   output logic             rsp_found,
   output logic [AW-1:0]    rsp_addr,
   output logic [TW-1:0]    rsp_time,
   output logic             breq,
   output logic [TW-1:0]    breq_time,
   output logic [CNT_W-1:0] cnt_ident,
   output logic [CNT_W-1:0] cnt_dupq,
   output logic [CNT_W-1:0] cnt_evict,
   output logic [CNT_W-1:0] cnt_missrm,
   output logic [CNT_W-1:0] cnt_issued,
   output logic [CNT_W-1:0] cnt_squash
);

   localparam int OFF = $clog2(BLK_BYTES);
   localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW  = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pf_cand_queue: DEPTH must be at least 2");
   end
   if ((BLK_BYTES < 2) || ((BLK_BYTES & (BLK_BYTES - 1)) != 0)) begin : g_bad_blk
      $error("pf_cand_queue: BLK_BYTES must be a power of two of at least 2");
   end
   if (OFF >= AW) begin : g_bad_aw
      $error("pf_cand_queue: AW too small for BLK_BYTES");
   end
   if (DLW > TW) begin : g_bad_dlw
      $error("pf_cand_queue: DLW must not exceed TW");
   end

   pfq_op_e          op;
   logic [IW-1:0]    op_idx;
   logic [AW-1:0]    wr_addr;
   logic [TW-1:0]    wr_time;
   logic [AW-1:0]    cmp_key;
   logic [CW-1:0]    count;
   logic [AW-1:0]    head_addr;
   logic [TW-1:0]    head_time;
   logic [TW-1:0]    tail_time;
   logic             hit;
   logic [IW-1:0]    hit_idx;
   logic [NSTAT-1:0] stat_inc;
   logic [CNT_W-1:0] stat_cnt [NSTAT];

   pfq_ctrl #(
      .DEPTH           (DEPTH),
      .AW              (AW),
      .TW              (TW),
      .DLW             (DLW),
      .OFF             (OFF),
      .SERIAL_SQUASH   (SERIAL_SQUASH),
      .CHECK_AT_INSERT (CHECK_AT_INSERT),
      .DATA_ONLY       (DATA_ONLY)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .miss_valid    (miss_valid),
      .miss_ready    (miss_ready),
      .miss_addr     (miss_addr),
      .miss_time     (miss_time),
      .miss_uncached (miss_uncached),
      .miss_ifetch   (miss_ifetch),
      .cand_valid    (cand_valid),
      .cand_ready    (cand_ready),
      .cand_addr     (cand_addr),
      .cand_delay    (cand_delay),
      .cl_addr       (cl_addr),
      .cl_hit        (cl_hit),
      .mq_addr       (mq_addr),
      .mq_hit        (mq_hit),
      .iss_req       (iss_req),
      .iss_ready     (iss_ready),
      .rsp_valid     (rsp_valid),
      .rsp_found     (rsp_found),
      .rsp_addr      (rsp_addr),
      .rsp_time      (rsp_time),
      .breq          (breq),
      .breq_time     (breq_time),
      .op            (op),
      .op_idx        (op_idx),
      .wr_addr       (wr_addr),
      .wr_time       (wr_time),
      .cmp_key       (cmp_key),
      .count         (count),
      .head_addr     (head_addr),
      .head_time     (head_time),
      .tail_time     (tail_time),
      .hit           (hit),
      .hit_idx       (hit_idx),
      .stat_inc      (stat_inc)
   );

   pfq_store #(
      .DEPTH (DEPTH),
      .AW    (AW),
      .TW    (TW)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .op_idx    (op_idx),
      .wr_addr   (wr_addr),
      .wr_time   (wr_time),
      .cmp_key   (cmp_key),
      .count     (count),
      .head_addr (head_addr),
      .head_time (head_time),
      .tail_time (tail_time),
      .hit       (hit),
      .hit_idx   (hit_idx)
   );

   pfq_stats #(
      .N     (NSTAT),
      .CNT_W (CNT_W)
   ) u_stats (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (stat_inc),
      .cnt   (stat_cnt)
   );

   assign cnt_ident  = stat_cnt[STAT_IDENT];
   assign cnt_dupq   = stat_cnt[STAT_DUPQ];
   assign cnt_evict  = stat_cnt[STAT_EVICT];
   assign cnt_missrm = stat_cnt[STAT_MISSRM];
   assign cnt_issued = stat_cnt[STAT_ISSUED];
   assign cnt_squash = stat_cnt[STAT_SQUASH];

endmodule

// File: rtl/pf_cand_queue_chk.sv
module pf_cand_queue_chk #(
   parameter int AW        = 32,
   parameter int BLK_BYTES = 64,
   parameter int CNT_W     = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             miss_valid,
   input logic             cand_valid,
   input logic             cand_ready,
   input logic             iss_ready,
   input logic             rsp_valid,
   input logic             rsp_found,
   input logic [AW-1:0]    rsp_addr,
   input logic [AW-1:0]    mq_addr,
   input logic             breq,
   input logic [CNT_W-1:0] cnt_ident,
   input logic [CNT_W-1:0] cnt_evict,
   input logic [CNT_W-1:0] cnt_issued,
   input logic [CNT_W-1:0] cnt_squash
);

   localparam logic [AW-1:0] LOW = AW'(BLK_BYTES - 1);

   AST_MISS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      miss_valid |-> (!cand_ready && !iss_ready)); // R10

   AST_BREQ_FROM_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(breq) |-> $past(cand_valid && cand_ready)); // R8

   AST_RSP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_found) |-> ((rsp_addr & LOW) == '0)); // R1

   AST_MQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (mq_addr & LOW) == '0); // R1

   AST_ISSUED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_issued != $past(cnt_issued)) |-> $past(rsp_valid && rsp_found)); // R11

   AST_IDENT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_ident != $past(cnt_ident)) |-> $past(cand_valid && cand_ready)); // R11

   AST_EVICT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_evict != $past(cnt_evict)) |-> ($past(cand_valid && cand_ready) && breq)); // R7

   AST_SQUASH_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_squash != $past(cnt_squash)) |-> !$past(cand_ready)); // R4

endmodule

bind pf_cand_queue pf_cand_queue_chk #(
   .AW        (AW),
   .BLK_BYTES (BLK_BYTES),
   .CNT_W     (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .miss_valid (miss_valid),
   .cand_valid (cand_valid),
   .cand_ready (cand_ready),
   .iss_ready  (iss_ready),
   .rsp_valid  (rsp_valid),
   .rsp_found  (rsp_found),
   .rsp_addr   (rsp_addr),
   .mq_addr    (mq_addr),
   .breq       (breq),
   .cnt_ident  (cnt_ident),
   .cnt_evict  (cnt_evict),
   .cnt_issued (cnt_issued),
   .cnt_squash (cnt_squash)
);

// File: tb/pf_cand_queue_tb.sv
module pf_cand_queue_tb;

   localparam int DEPTH = 8;
   localparam int AW    = 32;
   localparam int TW    = 16;
   localparam int DLW   = 8;
   localparam int BLK   = 64;
   localparam int CNTW  = 16;
   localparam bit SQ    = 1'b1;
   localparam bit CAI   = 1'b0;
   localparam bit DONLY = 1'b1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic            miss_valid = 0, miss_uncached = 0, miss_ifetch = 0;
   logic [AW-1:0]   miss_addr = 0;
   logic [TW-1:0]   miss_time = 0;
   logic            cand_valid = 0;
   logic [AW-1:0]   cand_addr = 0;
   logic [DLW-1:0]  cand_delay = 0;
   logic            iss_req = 0;
   logic            miss_ready, cand_ready, iss_ready;
   logic [AW-1:0]   cl_addr, mq_addr, rsp_addr;
   logic            cl_hit, mq_hit, rsp_valid, rsp_found, breq;
   logic [TW-1:0]   rsp_time, breq_time;
   logic [CNTW-1:0] cnt_ident, cnt_dupq, cnt_evict, cnt_missrm, cnt_issued, cnt_squash;

   // Environment: bit 12 marks a block present in the cache, bit 13 an outstanding miss.
   assign cl_hit = cl_addr[12];
   assign mq_hit = mq_addr[13];

   pf_cand_queue #(
      .DEPTH(DEPTH), .AW(AW), .TW(TW), .DLW(DLW), .BLK_BYTES(BLK), .CNT_W(CNTW),
      .SERIAL_SQUASH(SQ), .CHECK_AT_INSERT(CAI), .DATA_ONLY(DONLY)
   ) u_dut (
      .clk(clk), .rst_n(rst_n),
      .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
      .miss_time(miss_time), .miss_uncached(miss_uncached), .miss_ifetch(miss_ifetch),
      .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_addr(cand_addr),
      .cand_delay(cand_delay), .cl_addr(cl_addr), .cl_hit(cl_hit),
      .mq_addr(mq_addr), .mq_hit(mq_hit), .iss_req(iss_req), .iss_ready(iss_ready),
      .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_addr(rsp_addr),
      .rsp_time(rsp_time), .breq(breq), .breq_time(breq_time),
      .cnt_ident(cnt_ident), .cnt_dupq(cnt_dupq), .cnt_evict(cnt_evict),
      .cnt_missrm(cnt_missrm), .cnt_issued(cnt_issued), .cnt_squash(cnt_squash)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct { logic [AW-1:0] a; logic [TW-1:0] t; } ent_t;
   ent_t q[$];
   int            mst = 0; // 0 idle, 1 match, 2 squash, 3 issue
   logic [AW-1:0] mblk = 0;
   logic [TW-1:0] mtime = 0, ltime = 0, mbtime = 0;
   logic          mbreq = 0;
   int c_ident = 0, c_dupq = 0, c_evict = 0, c_missrm = 0, c_issued = 0, c_squash = 0;

   function automatic logic [AW-1:0] blk(logic [AW-1:0] a);
      return a & ~AW'(BLK - 1);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare();
      logic e_mr, e_cr, e_ir, e_rv, e_rf;
      e_mr = (mst == 0);
      e_cr = e_mr && !miss_valid;
      e_ir = e_cr && !cand_valid;
      e_rv = 0; e_rf = 0;
      if (mst == 3) begin
         if (q.size() == 0) e_rv = 1;
         else if (CAI || !q[0].a[12]) begin e_rv = 1; e_rf = 1; end
      end
      check("R10 miss_ready", 32'(miss_ready), 32'(e_mr));
      check("R10 cand_ready", 32'(cand_ready), 32'(e_cr));
      check("R10 iss_ready", 32'(iss_ready), 32'(e_ir));
      check("R9 rsp_valid", 32'(rsp_valid), 32'(e_rv));
      if (e_rv) check("R9 rsp_found", 32'(rsp_found), 32'(e_rf));
      if (e_rv && e_rf) begin
         check("R9 rsp_addr order", rsp_addr, q[0].a);
         check("R5 rsp_time", 32'(rsp_time), 32'(q[0].t));
      end
      if (mst == 0) check("R1 mq_addr block", mq_addr, blk(cand_addr));
      check("R8 breq", 32'(breq), 32'(mbreq));
      if (mbreq) check("R8 breq_time", 32'(breq_time), 32'(mbtime));
      check("R11 cnt_ident", 32'(cnt_ident), 32'(c_ident));
      check("R6 cnt_dupq", 32'(cnt_dupq), 32'(c_dupq));
      check("R7 cnt_evict", 32'(cnt_evict), 32'(c_evict));
      check("R3 cnt_missrm (R2 filter)", 32'(cnt_missrm), 32'(c_missrm));
      check("R11 cnt_issued", 32'(cnt_issued), 32'(c_issued));
      check("R4 cnt_squash", 32'(cnt_squash), 32'(c_squash));
   endtask

   task automatic model_step();
      bit removed = 0;
      case (mst)
         0: begin
            if (miss_valid) begin
               if (!miss_uncached && !(DONLY && miss_ifetch)) begin
                  mblk = blk(miss_addr); mtime = miss_time; ltime = miss_time; mst = 1;
               end
            end else if (cand_valid) begin
               logic [AW-1:0] b;
               logic [TW-1:0] t;
               bit dup = 0;
               b = blk(cand_addr);
               t = ltime + TW'(cand_delay);
               c_ident++;
               foreach (q[i]) if (q[i].a == b) dup = 1;
               if ((CAI && b[12]) || b[13]) begin
               end else if (dup) c_dupq++;
               else begin
                  if (q.size() == DEPTH) begin void'(q.pop_front()); c_evict++; end
                  q.push_back('{a: b, t: t});
                  mbreq = 1; mbtime = t;
               end
            end else if (iss_req) mst = 3;
         end
         1: begin
            for (int i = 0; i < q.size(); i++) begin
               if (q[i].a == mblk) begin q.delete(i); c_missrm++; removed = 1; break; end
            end
            mst = SQ ? 2 : 0;
         end
         2: begin
            if (q.size() > 0 && q[$].t >= mtime) begin
               void'(q.pop_back()); c_squash++; removed = 1;
            end else mst = 0;
         end
         default: begin
            if (q.size() == 0) mst = 0;
            else begin
               ent_t h;
               h = q.pop_front(); removed = 1;
               if (CAI || !h.a[12]) begin c_issued++; mst = 0; end
            end
         end
      endcase
      if (removed && q.size() == 0) mbreq = 0;
   endtask

   function automatic logic [AW-1:0] raddr();
      logic [AW-1:0] a;
      a = (AW'($urandom_range(0, 11)) << 6) | AW'($urandom_range(0, 63));
      if ($urandom_range(0, 4) == 0) a = a | 32'h1000;
      if ($urandom_range(0, 6) == 0) a = a | 32'h2000;
      return a;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      int pm[3] = '{3, 20, 8};
      int pc[3] = '{70, 45, 10};
      int pi[3] = '{5, 30, 80};
      logic [TW-1:0] tnow;
      tnow = 0;
      repeat (3) @(negedge clk);
      // R12: state under reset
      check("R12 breq at reset", 32'(breq), 0);
      check("R12 cnt_ident at reset", 32'(cnt_ident), 0);
      check("R12 cnt_issued at reset", 32'(cnt_issued), 0);
      check("R12 idle at reset", 32'(miss_ready), 1);
      rst_n = 1'b1;
      for (int ph = 0; ph < 3; ph++) begin
         for (int cyc = 0; cyc < 1500; cyc++) begin
            @(negedge clk);
            miss_valid    = ($urandom_range(0, 99) < pm[ph]);
            miss_addr     = raddr();
            tnow          = tnow + TW'($urandom_range(0, 3));
            miss_time     = tnow;
            miss_uncached = ($urandom_range(0, 7) == 0);
            miss_ifetch   = ($urandom_range(0, 5) == 0);
            cand_valid    = ($urandom_range(0, 99) < pc[ph]);
            cand_addr     = raddr();
            cand_delay    = DLW'($urandom_range(0, 15));
            iss_req       = ($urandom_range(0, 99) < pi[ph]);
            #1;
            compare();
            model_step();
         end
      end
      @(negedge clk);
      miss_valid = 0; cand_valid = 0; iss_req = 0;
      #1;
      compare();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule